// File: doc/BRIEF.md
# CB-Prefix Bit Manipulation Unit

This block executes the second byte of a prefixed 8-bit instruction group covering rotates, shifts, the nibble swap, and the bit test, set and clear operations. It takes three inputs: the opcode byte, the operand value already fetched from the selected register or from memory, and the current flag byte. It returns the new operand value, the new flag byte and a write-enable. It also reports which operand slot the opcode names, and whether that slot is the memory operand addressed through the HL pair. Prefix fetch, memory access and the register file belong to the surrounding core.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream through one output register.

- A request is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A full output register therefore stalls the input for exactly as long as `out_ready` stays low.
- Once `out_valid` is high, the result payload holds steady until the cycle in which `out_ready` is seen high.
- With `out_ready` held high, the unit accepts one request per cycle. Each result appears one cycle after its request is accepted.

Top module: `cbu_unit`

## Requirements
- R1: `out_slot` equals opcode bits 2:0, with 0..7 naming B, C, D, E, H, L, memory at HL, A. `out_slot_mem` is 1 exactly when the slot is 6.
- R2: Opcodes 0x00-0x07 rotate left circularly: result = {a[6:0], a[7]}, and carry takes a[7].
- R3: Opcodes 0x08-0x0F rotate right circularly: result = {a[0], a[7:1]}, and carry takes a[0].
- R4: Opcodes 0x10-0x17 rotate left through carry: result = {a[6:0], old C}, and carry takes a[7].
- R5: Opcodes 0x18-0x1F rotate right through carry: result = {old C, a[7:1]}, and carry takes a[0].
- R6: Opcodes 0x20-0x27 shift left: result = {a[6:0], 0}, and carry takes a[7].
- R7: Opcodes 0x28-0x2F shift right arithmetically: result = {a[7], a[7:1]}, and carry takes a[0].
- R8: Opcodes 0x30-0x37 swap the nibbles: result = {a[3:0], a[7:4]}. N, H and C are all 0, and Z is 1 when the result is 0.
- R9: Opcodes 0x38-0x3F shift right logically: result = {0, a[7:1]}, and carry takes a[0].
- R10: The flag byte has Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, and its output low nibble is always 0. For R2-R7 and R9, N and H are 0, Z is 1 when the result is 0, and the write-enable is 1.
- R11: Opcodes 0x40-0x7F test bit n, where n is opcode bits 5:3. Z = NOT a[n], N = 0, H = 1, and C is the input C. The write-enable is 0 and the result equals the operand.
- R12: Opcodes 0x80-0xBF clear bit n and opcodes 0xC0-0xFF set bit n, where n is opcode bits 5:3. No other bit changes. The flag high nibble passes through unchanged, and the write-enable is 1.
- R13: A result appears with `out_valid` in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds steady.
- R14: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_opcode | input | 8 | Second opcode byte |
| in_operand | input | 8 | Operand value read from the selected slot |
| in_flags | input | 8 | Current flag byte |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_result | output | 8 | New operand value |
| out_flags | output | 8 | New flag byte |
| out_wr_en | output | 1 | Result must be written back to the slot |
| out_slot | output | 3 | Decoded operand slot |
| out_slot_mem | output | 1 | Slot is the memory operand at HL |

## Verification
The assertions rely on two properties of the inputs. First, the opcode, operand and flag inputs hold known values in every cycle where `in_valid` is high. Second, `in_valid` and `out_ready` are known from the end of reset onward. The assertions place no constraint on the low nibble of `in_flags`.

The stimulus drives every input at the falling clock edge, away from the sampling edge, and never leaves them undriven. It sweeps all 256 opcodes against all 256 operand values. For each pair it derives a flag byte from the operand and opcode bits, so both carry polarities reach the rotate-through-carry forms. A separate sequence holds `out_ready` low to exercise the stall.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int DATA_W   = 8;
  localparam int HALF_W   = DATA_W / 2;
  localparam int SLOT_W   = 3;
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MEM_SLOT = 6;
  localparam int FLAG_Z   = 7;
  localparam int FLAG_N   = 6;
  localparam int FLAG_H   = 5;
  localparam int FLAG_C   = 4;

  typedef enum logic [3:0] {
    OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SWAP, OP_SRL,
    OP_BIT, OP_RES, OP_SET
  } cb_op_e;

  typedef struct packed {
    cb_op_e            op;
    logic [IDX_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot;
    logic              is_mem;
  } cb_dec_t;

  typedef struct packed {
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] flags;
    logic              wr_en;
    logic [SLOT_W-1:0] slot;
    logic              is_mem;
  } cb_res_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  output cb_dec_t           dec
);
  logic [1:0]       group;
  logic [IDX_W-1:0] sub;

  assign group = opcode[7:6];
  assign sub   = opcode[5:3];

  always_comb begin
    dec.bit_idx = sub;
    dec.slot    = opcode[SLOT_W-1:0];
    dec.is_mem  = (opcode[SLOT_W-1:0] == SLOT_W'(MEM_SLOT));
    unique case (group)
      2'b00: begin
        unique case (sub)
          3'd0:    dec.op = OP_RLC;
          3'd1:    dec.op = OP_RRC;
          3'd2:    dec.op = OP_RL;
          3'd3:    dec.op = OP_RR;
          3'd4:    dec.op = OP_SLA;
          3'd5:    dec.op = OP_SRA;
          3'd6:    dec.op = OP_SWAP;
          default: dec.op = OP_SRL;
        endcase
      end
      2'b01:   dec.op = OP_BIT;
      2'b10:   dec.op = OP_RES;
      default: dec.op = OP_SET;
    endcase
  end
endmodule

// File: rtl/cbu_shift.sv
module cbu_shift
  import cbu_pkg::*;
(
  input  cb_op_e            op,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flags
);
  logic msb, lsb, carry_out;

  assign msb = operand[DATA_W-1];
  assign lsb = operand[0];

  always_comb begin
    result    = operand;
    carry_out = 1'b0;
    unique case (op)
      OP_RLC:  begin result = {operand[DATA_W-2:0], msb};      carry_out = msb; end
      OP_RRC:  begin result = {lsb, operand[DATA_W-1:1]};      carry_out = lsb; end
      OP_RL:   begin result = {operand[DATA_W-2:0], carry_in}; carry_out = msb; end
      OP_RR:   begin result = {carry_in, operand[DATA_W-1:1]}; carry_out = lsb; end
      OP_SLA:  begin result = {operand[DATA_W-2:0], 1'b0};     carry_out = msb; end
      OP_SRA:  begin result = {msb, operand[DATA_W-1:1]};      carry_out = lsb; end
      OP_SRL:  begin result = {1'b0, operand[DATA_W-1:1]};     carry_out = lsb; end
      OP_SWAP: begin
        result    = {operand[HALF_W-1:0], operand[DATA_W-1:HALF_W]};
        carry_out = 1'b0;
      end
      default: begin result = operand; carry_out = 1'b0; end
    endcase
  end

  always_comb begin
    flags         = '0;
    flags[FLAG_Z] = (result == '0);
    flags[FLAG_C] = carry_out;
  end
endmodule

// File: rtl/cbu_bitop.sv
module cbu_bitop
  import cbu_pkg::*;
(
  input  cb_op_e            op,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        flags_hi,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flags,
  output logic              wr_en
);
  logic [DATA_W-1:0] mask;
  logic              tested;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (bit_idx == IDX_W'(i));
  end

  assign tested = |(operand & mask);

  always_comb begin
    result = operand;
    flags  = {flags_hi, 4'b0000};
    wr_en  = 1'b1;
    unique case (op)
      OP_BIT: begin
        result        = operand;
        flags         = '0;
        flags[FLAG_Z] = ~tested;
        flags[FLAG_H] = 1'b1;
        flags[FLAG_C] = flags_hi[FLAG_C-4];
        wr_en         = 1'b0;
      end
      OP_RES:  result = operand & ~mask;
      OP_SET:  result = operand | mask;
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/cbu_unit.sv
module cbu_unit
  import cbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_opcode,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [DATA_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [DATA_W-1:0] out_flags,
  output logic              out_wr_en,
  output logic [SLOT_W-1:0] out_slot,
  output logic              out_slot_mem
);
  cb_dec_t           dec;
  cb_res_t           next_res, res_q;
  logic [DATA_W-1:0] sh_result, sh_flags, bo_result, bo_flags;
  logic              bo_wr_en;
  logic              valid_q;
  logic              is_bitgroup;

  cbu_decode i_decode (.opcode(in_opcode), .dec(dec));

  cbu_shift i_shift (
    .op(dec.op), .operand(in_operand), .carry_in(in_flags[FLAG_C]),
    .result(sh_result), .flags(sh_flags)
  );

  cbu_bitop i_bitop (
    .op(dec.op), .bit_idx(dec.bit_idx), .operand(in_operand),
    .flags_hi(in_flags[DATA_W-1:HALF_W]),
    .result(bo_result), .flags(bo_flags), .wr_en(bo_wr_en)
  );

  assign is_bitgroup = (dec.op == OP_BIT) || (dec.op == OP_RES) || (dec.op == OP_SET);

  always_comb begin
    next_res.slot   = dec.slot;
    next_res.is_mem = dec.is_mem;
    if (is_bitgroup) begin
      next_res.result = bo_result;
      next_res.flags  = bo_flags;
      next_res.wr_en  = bo_wr_en;
    end else begin
      next_res.result = sh_result;
      next_res.flags  = sh_flags;
      next_res.wr_en  = 1'b1;
    end
  end

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) res_q <= next_res;
    end
  end

  assign out_valid    = valid_q;
  assign out_result   = res_q.result;
  assign out_flags    = res_q.flags;
  assign out_wr_en    = res_q.wr_en;
  assign out_slot     = res_q.slot;
  assign out_slot_mem = res_q.is_mem;

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_wr_en) && $stable(out_slot)));

  assert_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_flag_nibble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3:0] == 4'b0000));

  assert_mem_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_slot_mem == (out_slot == SLOT_W'(MEM_SLOT))));

  assert_bit_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_opcode[7:6] == 2'b01) |=>
      (!out_wr_en && out_result == $past(in_operand) && out_flags[FLAG_H]));

  assert_setres_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_opcode[7]) |=>
      (out_wr_en && out_flags == ($past(in_flags) & 8'hF0)));

  assert_swap_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_opcode[7:3] == 5'b00110) |=>
      (out_flags[FLAG_N] == 1'b0 && out_flags[FLAG_H] == 1'b0 && out_flags[FLAG_C] == 1'b0));
endmodule

// File: tb/test_cbu_unit.sv
module test_cbu_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = '0, in_operand = '0, in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result, out_flags;
  logic       out_wr_en;
  logic [2:0] out_slot;
  logic       out_slot_mem;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cbu_unit i_cbu_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_opcode, .in_operand, .in_flags,
    .out_valid, .out_ready, .out_result, .out_flags, .out_wr_en, .out_slot, .out_slot_mem
  );

  function automatic void model(input logic [7:0] op, input logic [7:0] a, input logic [7:0] f,
                                output logic [7:0] r, output logic [7:0] fl,
                                output logic we, output string tag);
    logic c;
    int   n;
    n  = int'(op[5:3]);
    c  = 1'b0;
    we = 1'b1;
    fl = 8'h00;
    r  = a;
    if (op[7:6] == 2'b00) begin
      case (op[5:3])
        3'd0: begin r = (a << 1) | (a >> 7);   c = a[7]; tag = "R2"; end
        3'd1: begin r = (a >> 1) | (a << 7);   c = a[0]; tag = "R3"; end
        3'd2: begin r = (a << 1) | 8'(f[4]);   c = a[7]; tag = "R4"; end
        3'd3: begin r = (a >> 1) | (f[4] ? 8'h80 : 8'h00); c = a[0]; tag = "R5"; end
        3'd4: begin r = a << 1;                c = a[7]; tag = "R6"; end
        3'd5: begin r = (a >> 1) | (a & 8'h80); c = a[0]; tag = "R7"; end
        3'd6: begin r = (a << 4) | (a >> 4);   c = 1'b0; tag = "R8"; end
        default: begin r = a >> 1;             c = a[0]; tag = "R9"; end
      endcase
      fl = ((r == 8'h00) ? 8'h80 : 8'h00) | (c ? 8'h10 : 8'h00);
    end else if (op[7:6] == 2'b01) begin
      r   = a;
      we  = 1'b0;
      fl  = (a[n] ? 8'h00 : 8'h80) | 8'h20 | (f & 8'h10);
      tag = "R11";
    end else begin
      r   = op[6] ? (a | (8'h01 << n)) : (a & ~(8'h01 << n));
      fl  = f & 8'hF0;
      tag = "R12";
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_flags(input logic [7:0] op, input logic [7:0] a);
    return {a[3] ^ op[1], a[5], a[6] ^ op[0], a[0] ^ a[7] ^ op[3], 4'b0000};
  endfunction

  logic [7:0] e_r, e_f, p_op;
  logic       e_we;
  string      e_tag;
  bit         pending;

  task automatic check_pending();
    string ftag;
    check(out_valid === 1'b1, "R13", "out_valid", 32'(out_valid), 32'd1);
    check(out_result === e_r, e_tag, "result", 32'(out_result), 32'(e_r));
    ftag = (p_op[7:6] == 2'b00 && p_op[5:3] != 3'd6) ? "R10" : e_tag;
    check(out_flags === e_f, ftag, "flags", 32'(out_flags), 32'(e_f));
    check(out_wr_en === e_we, e_tag, "wr_en", 32'(out_wr_en), 32'(e_we));
    check(out_slot === p_op[2:0] && out_slot_mem === (p_op[2:0] == 3'd6), "R1", "slot",
          32'({out_slot_mem, out_slot}), 32'({p_op[2:0] == 3'd6, p_op[2:0]}));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14: reset state
    check(out_valid === 1'b0, "R14", "out_valid", 32'(out_valid), 32'd0);
    check(in_ready === 1'b1, "R14", "in_ready", 32'(in_ready), 32'd1);

    // Exhaustive sweep, one request per cycle, out_ready held high
    pending = 0;
    for (int op = 0; op < 256; op++) begin
      for (int a = 0; a < 256; a++) begin
        if (pending) check_pending();
        in_valid   = 1'b1;
        in_opcode  = 8'(op);
        in_operand = 8'(a);
        in_flags   = mk_flags(8'(op), 8'(a));
        model(in_opcode, in_operand, in_flags, e_r, e_f, e_we, e_tag);
        p_op    = in_opcode;
        pending = 1;
        @(negedge clk);
      end
    end
    check_pending();
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R13", "drain", 32'(out_valid), 32'd0);

    // Back-pressure: swap of 0x5A held while out_ready is low
    out_ready  = 1'b0;
    in_valid   = 1'b1;
    in_opcode  = 8'h37;
    in_operand = 8'h5A;
    in_flags   = 8'hF0;
    @(negedge clk);
    check(out_result === 8'hA5 && out_flags === 8'h00, "R8", "swap",
          32'({out_result, out_flags}), 32'hA500);
    check(in_ready === 1'b0, "R13", "stall in_ready", 32'(in_ready), 32'd0);
    in_opcode  = 8'hC7;
    in_operand = 8'h00;
    in_flags   = 8'h50;
    @(negedge clk);
    check(out_valid === 1'b1 && out_result === 8'hA5, "R13", "hold",
          32'({out_valid, out_result}), 32'h1A5);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_result === 8'h01 && out_flags === 8'h50 && out_wr_en === 1'b1, "R12", "set after stall",
          32'({out_result, out_flags, 7'd0, out_wr_en}), 32'h015001);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R13", "empty", 32'(out_valid), 32'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule